// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Gate

This block holds a two-bit coalescing state for each of `NUM_SRC` interrupt sources. The state decides whether an incoming event is passed on to a downstream router. An event from an idle source is forwarded once. Further events that arrive before software acknowledges the source are folded into a single "queued" mark, so each source shows up downstream at most once at a time. Events come from a hardware line per source or from a store to the source's trigger page.

Software works through a simple request port. Each source has a page of `2^PAGE_SHIFT` bytes, and the source number sits in the address bits above the page. When `PAGE_SHIFT` is 13 or 17 the page is split in two: the lower half triggers the source and the upper half manages it. With any other shift, one page does both jobs. Fixed offsets in the management area select atomic operations: end-of-interrupt, read state, or force state. Each load returns the state as it was before the operation.

A source marked level-sensitive keeps an asserted bit, which is the registered input line. If an end-of-interrupt arrives while that bit is still set, the source fires again. Forwarded events wait in a per-source notify flag. They leave through a valid/ready port, lowest source number first.

Top module: `pq_event_gate`

## Requirements
- R1: After reset every source state is 00, `ntf_valid` is 0 and `rsp_valid` is 0.
- R2: The state is written {P,Q}. A trigger on 00 gives 10 and raises one notification. A trigger on 10 or 11 gives 11 and raises no notification.
- R3: State 01 is off. A trigger leaves it at 01 and sends nothing, and an end-of-interrupt also leaves it at 01.
- R4: End-of-interrupt takes 10 to 00, and takes 11 to 10 with a fresh notification.
- R5: A load at management offset 0x000 performs end-of-interrupt and returns the previous state.
- R6: A store at management offset 0x400 performs end-of-interrupt only while `store_eoi_en` is 1. Otherwise it changes nothing.
- R7: A load at management offset 0x800 returns the state and leaves it unchanged.
- R8: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11. They return the previous state and never raise a notification.
- R9: The source index is `req_addr[ADDR_W-1:PAGE_SHIFT]` and the operation is `req_addr[11:8]`. With a split page, `req_addr[PAGE_SHIFT-1]`=1 selects management and any store to the lower half triggers the source. With a single page, any store other than offset 0x400 triggers. Every other load returns zero with no effect.
- R10: A rising edge on `irq_in[i]` is a trigger. An edge source that is still held high does not fire again on end-of-interrupt.
- R11: For a level source (`level_sel[i]`=1), an end-of-interrupt while the line is still high results in 10 with a new notification. Lowering the line does not clear P.
- R12: When several notifications are waiting, `ntf_src` gives the lowest waiting source. It stays valid until `ntf_ready`, and one is removed per accepted cycle.
- R13: A load answers one cycle after the request with `rsp_valid`=1, the state in `rsp_data[1:0]` and zeros above. A hardware trigger in the same cycle as a software operation on the same source applies after that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Hardware interrupt lines, one per source |
| level_sel | input | NUM_SRC | 1 marks a source as level-sensitive |
| store_eoi_en | input | 1 | Enables end-of-interrupt by store |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address: source index, page half and offset |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Previous state in bits 1:0 |
| ntf_valid | output | 1 | A notification is waiting |
| ntf_ready | input | 1 | Downstream accepts the notification |
| ntf_src | output | SRC_W | Source number of the waiting notification |

## Verification
The assertions assume that `irq_in` is synchronous to `clk`, that `level_sel` does not change while its source is active, and that each request lasts a single cycle with one request per cycle at most. The bench drives every input at the falling edge. Its addresses always fall inside the configured sources and use only the defined 8-byte offsets, apart from the one deliberately undefined offset used for R9. A behavioural model that tracks state, line history and waiting notifications as integers is compared against the outputs on every cycle.

// File: rtl/pq_event_gate.sv
module pq_event_gate #(
  parameter int NUM_SRC = 8,
  parameter int PAGE_SHIFT = 13,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = SRC_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] level_sel,
  input  logic               store_eoi_en,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [63:0]        rsp_data,
  output logic               ntf_valid,
  input  logic               ntf_ready,
  output logic [SRC_W-1:0]   ntf_src
);

  localparam bit SPLIT = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  // {fire, next_state}
  function automatic logic [2:0] pq_trig(input logic [1:0] s);
    case (s)
      2'b00:   return 3'b110;
      2'b01:   return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] pq_eoi(input logic [1:0] s, input logic lvl);
    if (s == 2'b01) return 3'b001;
    if (s[0] | lvl) return 3'b110;
    return 3'b000;
  endfunction

  logic [NUM_SRC-1:0][1:0] pq_q, pq_d;
  logic [NUM_SRC-1:0]      line_q, npend_q, fire, hit, pop_mask;
  logic                    in_mgmt;

  wire [SRC_W-1:0] req_src  = req_addr[ADDR_W-1:PAGE_SHIFT];
  wire [3:0]       req_op   = req_addr[11:8];
  wire             unused_lo = &{1'b0, req_addr[7:0]};
  wire             in_range = ({1'b0, req_src} < (SRC_W+1)'(NUM_SRC));

  generate
    if (SPLIT) begin : g_split
      assign in_mgmt = req_addr[PAGE_SHIFT-1];
    end else begin : g_single
      assign in_mgmt = 1'b1;
    end
  endgenerate

  wire is_load  = req_valid & ~req_write;
  wire is_store = req_valid & req_write;
  wire do_set   = is_load & in_mgmt & (req_op[3:2] == 2'b11);
  wire do_eoi   = (is_load & in_mgmt & (req_op == 4'h0)) |
                  (is_store & in_mgmt & (req_op == 4'h4) & store_eoi_en);
  wire do_strig = is_store & (SPLIT ? ~in_mgmt : (req_op != 4'h4));
  wire rd_op    = (req_op == 4'h0) | (req_op == 4'h8) | (req_op[3:2] == 2'b11);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      logic [2:0] sw, hw;
      assign hit[i] = req_valid & in_range & (req_src == SRC_W'(i));
      always_comb begin
        sw = {1'b0, pq_q[i]};
        if (hit[i]) begin
          if (do_set)        sw = {1'b0, req_op[1:0]};
          else if (do_eoi)   sw = pq_eoi(pq_q[i], level_sel[i] & line_q[i]);
          else if (do_strig) sw = pq_trig(pq_q[i]);
        end
        hw = (irq_in[i] & ~line_q[i]) ? pq_trig(sw[1:0]) : {1'b0, sw[1:0]};
      end
      assign pq_d[i] = hw[1:0];
      assign fire[i] = sw[2] | hw[2];

      assert_off_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_q[i] == 2'b01 && !hit[i]) |=> pq_q[i] == 2'b01);
      assert_notify_has_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(npend_q[i]) |-> pq_q[i][1]);
      assert_p_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_q[i][1] && !hit[i]) |=> pq_q[i][1]);
    end
  endgenerate

  always_comb begin
    ntf_src = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (npend_q[k]) ntf_src = SRC_W'(k);
  end
  assign ntf_valid = |npend_q;
  assign pop_mask  = (ntf_valid & ntf_ready) ? (NUM_SRC'(1) << ntf_src) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q      <= '0;
      line_q    <= '0;
      npend_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pq_q      <= pq_d;
      line_q    <= irq_in;
      npend_q   <= (npend_q & ~pop_mask) | fire;
      rsp_valid <= is_load;
      rsp_data  <= (is_load & in_mgmt & in_range & rd_op) ? {62'b0, pq_q[req_src]} : '0;
    end
  end

  assert_load_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_stray_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  assert_notify_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> ntf_valid);

endmodule

// File: tb/pq_event_gate_test.sv
`timescale 1ns/1ps
module pq_event_gate_test;
  localparam int N = 8;
  localparam int AW = 3 + 13;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0, level_sel = 8'b0100_0000;
  logic store_eoi_en = 0, req_valid = 0, req_write = 0, ntf_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, ntf_valid;
  logic [63:0] rsp_data;
  logic [2:0] ntf_src;

  int total = 0, bad = 0;
  bit done = 0, model_on = 0;

  pq_event_gate uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel),
    .store_eoi_en(store_eoi_en), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pq[N], m_line[N], m_np[N];
  int m_rv, m_rd;

  function automatic int lowest();
    for (int k = 0; k < N; k++) if (m_np[k] != 0) return k;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin m_pq[k] = 0; m_line[k] = 0; m_np[k] = 0; end
      m_rv = 0; m_rd = 0;
    end else begin
      int s, op, hi, lw;
      s = int'(req_addr >> 13); hi = int'(req_addr[12]); op = int'(req_addr[11:8]);
      m_rv = (req_valid && !req_write) ? 1 : 0;
      m_rd = 0;
      if (m_rv == 1 && hi == 1 && (op == 0 || op == 8 || op >= 12)) m_rd = m_pq[s];
      lw = lowest();
      if (ntf_ready && lw >= 0) m_np[lw] = 0;
      for (int k = 0; k < N; k++) begin
        int p, f, eoi, trg;
        p = m_pq[k]; f = 0; eoi = 0; trg = 0;
        if (req_valid && s == k) begin
          if (!req_write && hi == 1) begin
            if (op >= 12) p = op - 12;
            else if (op == 0) eoi = 1;
          end
          if (req_write) begin
            if (hi == 1 && op == 4 && store_eoi_en) eoi = 1;
            if (hi == 0) trg = 1;
          end
        end
        if (eoi == 1 && p != 1) begin
          if ((p % 2) == 1 || (level_sel[k] && m_line[k] == 1)) begin p = 2; f = 1; end
          else p = 0;
        end
        if (trg == 1) begin if (p == 0) begin p = 2; f = 1; end else if (p >= 2) p = 3; end
        if (irq_in[k] && m_line[k] == 0) begin
          if (p == 0) begin p = 2; f = 1; end else if (p >= 2) p = 3;
        end
        m_pq[k] = p; m_line[k] = irq_in[k] ? 1 : 0;
        if (f == 1) m_np[k] = 1;
      end
    end
  end

  always @(negedge clk) if (model_on) begin
    int lw;
    lw = lowest();
    chk("R12 notify valid vs model", ntf_valid, (lw >= 0));
    if (lw >= 0) chk("R12 notify source vs model", ntf_src, lw);
    chk("R13 reply valid vs model", rsp_valid, m_rv);
    chk("R13 reply data vs model", rsp_data, m_rd);
  end

  task automatic acc(input bit wr, input int src, input bit hi, input int off, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr;
    req_addr = AW'((src << 13) | (int'(hi) << 12) | off);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    d = rsp_data;
  endtask

  task automatic pop(input string tag, input int src);
    @(negedge clk);
    chk(tag, ntf_valid, 1);
    chk(tag, ntf_src, src);
    ntf_ready = 1;
    @(negedge clk);
    ntf_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1; model_on = 1;
    // R1
    @(negedge clk);
    chk("R1 notify idle", ntf_valid, 0);
    chk("R1 reply idle", rsp_valid, 0);
    acc(0, 0, 1, 'h800, d); chk("R1 state zero", d, 0);
    // R2 / R9 store trigger
    acc(1, 3, 0, 0, d);
    chk("R2 notify raised", ntf_valid, 1); chk("R2 notify src", ntf_src, 3);
    acc(0, 3, 1, 'h800, d); chk("R2 pending", d, 2);
    acc(1, 3, 0, 'h100, d);
    acc(0, 3, 1, 'h800, d); chk("R2 queued", d, 3);
    pop("R2 single notify", 3);
    chk("R2 no second notify", ntf_valid, 0);
    // R4 / R5
    acc(0, 3, 1, 'h000, d); chk("R5 load eoi old", d, 3);
    chk("R4 retrigger notify", ntf_valid, 1);
    acc(0, 3, 1, 'h800, d); chk("R4 queued to pending", d, 2);
    pop("R4 retrigger src", 3);
    acc(0, 3, 1, 'h000, d); chk("R5 eoi old pending", d, 2);
    acc(0, 3, 1, 'h800, d); chk("R4 pending to reset", d, 0);
    chk("R4 no notify", ntf_valid, 0);
    // R6 / R8
    acc(0, 1, 1, 'hE00, d); chk("R8 set returns old", d, 0);
    chk("R8 set no notify", ntf_valid, 0);
    acc(1, 1, 1, 'h400, d);
    acc(0, 1, 1, 'h800, d); chk("R6 store eoi disabled", d, 2);
    store_eoi_en = 1;
    acc(1, 1, 1, 'h400, d);
    acc(0, 1, 1, 'h800, d); chk("R6 store eoi enabled", d, 0);
    // R7 / R8 / R3
    acc(0, 2, 1, 'hF00, d); chk("R8 set11 old", d, 0);
    acc(0, 2, 1, 'hD00, d); chk("R8 set01 old", d, 3);
    acc(0, 2, 1, 'h800, d); chk("R7 get off", d, 1);
    acc(0, 2, 1, 'h800, d); chk("R7 get unchanged", d, 1);
    acc(1, 2, 0, 0, d);
    acc(0, 2, 1, 'h800, d); chk("R3 trigger ignored", d, 1);
    chk("R3 no notify", ntf_valid, 0);
    acc(0, 2, 1, 'h000, d); chk("R3 eoi old", d, 1);
    acc(0, 2, 1, 'h800, d); chk("R3 eoi ignored", d, 1);
    chk("R3 eoi no notify", ntf_valid, 0);
    acc(0, 2, 1, 'hC00, d); chk("R8 set00 old", d, 1);
    // R10 edge source
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk); chk("R10 edge notify", ntf_valid, 1); chk("R10 edge src", ntf_src, 5);
    pop("R10 edge pop", 5);
    acc(0, 5, 1, 'h000, d); chk("R10 eoi old", d, 2);
    acc(0, 5, 1, 'h800, d); chk("R10 no level refire", d, 0);
    chk("R10 no notify when held", ntf_valid, 0);
    @(negedge clk); irq_in[5] = 0;
    // R11 level source
    @(negedge clk); irq_in[6] = 1;
    @(negedge clk); pop("R11 level notify", 6);
    irq_in[6] = 0;
    acc(0, 6, 1, 'h800, d); chk("R11 deassert keeps P", d, 2);
    @(negedge clk); irq_in[6] = 1;
    acc(0, 6, 1, 'h800, d); chk("R11 queued on reassert", d, 3);
    chk("R11 no extra notify", ntf_valid, 0);
    acc(0, 6, 1, 'h000, d); chk("R11 eoi old", d, 3);
    pop("R11 eoi from queued", 6);
    acc(0, 6, 1, 'h000, d); chk("R11 eoi held high old", d, 2);
    acc(0, 6, 1, 'h800, d); chk("R11 refire state", d, 2);
    pop("R11 held-high refire", 6);
    @(negedge clk); irq_in[6] = 0;
    acc(0, 6, 1, 'h000, d);
    acc(0, 6, 1, 'h800, d); chk("R11 eoi after drop", d, 0);
    // R12 priority
    @(negedge clk); irq_in[7] = 1; irq_in[4] = 1; irq_in[0] = 1;
    repeat (4) @(negedge clk);
    chk("R12 held while not ready", ntf_valid, 1);
    chk("R12 lowest first", ntf_src, 0);
    pop("R12 first", 0);
    pop("R12 second", 4);
    pop("R12 third", 7);
    chk("R12 drained", ntf_valid, 0);
    irq_in[7] = 0; irq_in[4] = 0; irq_in[0] = 0;
    // R13 ordering: set to 10 then hardware trigger gives 11
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'((1 << 13) | (1 << 12) | 'hE00); irq_in[1] = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R13 load returns old", rsp_data, 0);
    chk("R13 reply valid", rsp_valid, 1);
    acc(0, 1, 1, 'h800, d); chk("R13 mmio then hardware", d, 3);
    chk("R13 no notify", ntf_valid, 0);
    irq_in[1] = 0;
    // R9 odd loads
    acc(0, 1, 0, 'h800, d); chk("R9 trigger-half load zero", d, 0);
    acc(0, 1, 1, 'h300, d); chk("R9 undefined op zero", d, 0);
    acc(0, 1, 1, 'h800, d); chk("R9 state untouched", d, 3);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule